// File: doc/BRIEF.md
# Fracturable Six-Input Look-Up Table

This block is a configurable six-input look-up table. A 64-bit truth table sits in configuration storage next to a 2-bit mode word. A tree of 2:1 multiplexers reads the table, and each level of the tree is steered by one input, with the lowest input steering the level nearest the table. The block has three output groups, and each group is taken from a different level of the tree. One table can therefore act as a single six-input function, as a pair of five-input functions, or as a pair of four-input functions.

The two mode bits split the table. Each mode bit is ORed into one of the two upper inputs, so that input reads as a constant 1. Forcing the fifth input to 1 gives two independent four-input functions. Forcing the sixth input gives two five-input functions. All outputs are combinational from the inputs and the stored configuration, and every tap stays live in every mode. The table and the mode word are written from parallel buses, each under its own load strobe. After reset the table holds zero and the mode word holds 11.

Top module: `fraclut6`

## Requirements
- R1: While rst_n is low, the stored table is cleared to all zeros and the stored mode word is set to 2'b11. The mode word therefore reads 11 until it is first written.
- R2: If tbl_load is high at a rising clk edge, cfg_table is stored. If mode_load is high at a rising clk edge, cfg_mode is stored. The two strobes act independently of each other.
- R3: While a strobe is low, the matching stored value holds. Changes on cfg_table or cfg_mode have no effect on any output.
- R4: Stored mode bit 0 forces lut_in[4] to 1, and stored mode bit 1 forces lut_in[5] to 1. A mode bit of 0 passes the input through unchanged. Call the results f4 and f5.
- R5: lut6_out equals table bit T[{f5, f4, lut_in[3:0]}]. Here T[n] is bit n of the stored table.
- R6: lut5_out[0] equals T[{1'b0, f4, lut_in[3:0]}], and lut5_out[1] equals T[{1'b1, f4, lut_in[3:0]}].
- R7: lut4_out[0] equals T[lut_in[3:0]], and lut4_out[1] equals T[32 + lut_in[3:0]]. Neither depends on lut_in[5:4] or on the mode word.
- R8: With mode 11, lut6_out equals lut5_out[1], and neither output depends on lut_in[5:4].
- R9: All outputs follow a change on lut_in within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_load | input | 1 | Write strobe for the truth table |
| cfg_table | input | 64 | Truth table value to be stored |
| mode_load | input | 1 | Write strobe for the mode word |
| cfg_mode | input | 2 | Mode value to be stored: bit 0 forces input 4, bit 1 forces input 5 |
| lut_in | input | 6 | Function inputs |
| lut4_out | output | 2 | Outputs of the pair of four-input functions |
| lut5_out | output | 2 | Outputs of the pair of five-input functions |
| lut6_out | output | 1 | Output of the single six-input function |

## Verification
The bench checks the four-input taps at tree nodes 0 and 2. A tree that tapped adjacent nodes 0 and 1 would return the low half of the table on lut4_out[1]. The bench also checks each mode bit against the input it forces. A design with the mode bits swapped, or one that masked an input to 0 instead of forcing it to 1, would read the wrong quarter of the table. This shows up on lut6_out and lut5_out whenever the upper inputs sit at 0. Other runs load only the table after reset, to expose a wrong reset value of the mode word. A further run changes the configuration buses with both strobes low, so that a store that captured without its strobe changes the outputs.

// File: rtl/fraclut_pkg.sv
package fraclut_pkg;

    // Number of function inputs and derived sizes
    localparam int LUT_K  = 6;
    localparam int TBL_W  = 1 << LUT_K;
    localparam int MODE_W = 2;

    // Reset values of the configuration storage
    localparam logic [MODE_W-1:0] MODE_RST = '1;
    localparam logic [TBL_W-1:0]  TBL_RST  = '0;

    typedef struct packed {
        logic [TBL_W-1:0]  tbl;
        logic [MODE_W-1:0] mode;
    } cfg_t;

endpackage

// File: rtl/fraclut_cfg_store.sv
module fraclut_cfg_store
    import fraclut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_load,
    input  logic [TBL_W-1:0]  cfg_table,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] cfg_mode,
    output logic [TBL_W-1:0]  tbl_q,
    output logic [MODE_W-1:0] mode_q
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (tbl_load) begin
            cfg_d.tbl = cfg_table;
        end
        if (mode_load) begin
            cfg_d.mode = cfg_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.tbl  <= TBL_RST;
            cfg_q.mode <= MODE_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign tbl_q  = cfg_q.tbl;
    assign mode_q = cfg_q.mode;

    // R2
    tbl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_load |=> (tbl_q == $past(cfg_table)));

    // R2
    mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> (mode_q == $past(cfg_mode)));

    // R3
    tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_load |=> $stable(tbl_q));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode_q));

endmodule

// File: rtl/fraclut_force.sv
module fraclut_force
    import fraclut_pkg::*;
#(
    parameter int K  = LUT_K,
    parameter int MW = MODE_W
) (
    input  logic [K-1:0]  raw_in,
    input  logic [MW-1:0] mode,
    output logic [K-1:0]  eff_in
);

    localparam int FIRST_FORCED = K - MW;

    for (genvar i = 0; i < K; i++) begin : g_bit
        if (i >= FIRST_FORCED) begin : g_or
            // OR gate: a set mode bit pins this input high
            assign eff_in[i] = raw_in[i] | mode[i - FIRST_FORCED];
        end else begin : g_pass
            assign eff_in[i] = raw_in[i];
        end
    end

endmodule

// File: rtl/fraclut_mux_tree.sv
module fraclut_mux_tree
    import fraclut_pkg::*;
#(
    parameter int K = LUT_K
) (
    input  logic [(1<<K)-1:0] tbl,
    input  logic [K-1:0]      sel,
    output logic [1:0]        tap_lo,
    output logic [1:0]        tap_mid,
    output logic              tap_root
);

    // All tree nodes, level by level, in one flat vector.
    // Level k holds 2**(K-k) nodes starting at offset 2**(K+1) - 2**(K-k+1).
    localparam int NODES = (1 << (K + 1)) - 1;

    function automatic int lvl_base(input int k);
        return (1 << (K + 1)) - (1 << (K - k + 1));
    endfunction

    logic [NODES-1:0] node;

    assign node[TBL_W-1:0] = tbl;

    for (genvar k = 1; k <= K; k++) begin : g_lvl
        for (genvar j = 0; j < (1 << (K - k)); j++) begin : g_node
            assign node[lvl_base(k) + j] =
                sel[k-1] ? node[lvl_base(k-1) + 2*j + 1]
                         : node[lvl_base(k-1) + 2*j];
        end
    end

    // Split outputs: nodes 0 and 2 of level K-2, nodes 0 and 1 of level K-1
    assign tap_lo   = {node[lvl_base(K-2) + 2], node[lvl_base(K-2)]};
    assign tap_mid  = {node[lvl_base(K-1) + 1], node[lvl_base(K-1)]};
    assign tap_root = node[lvl_base(K)];

endmodule

// File: rtl/fraclut6.sv
module fraclut6
    import fraclut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_load,
    input  logic [TBL_W-1:0]  cfg_table,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [LUT_K-1:0]  lut_in,
    output logic [1:0]        lut4_out,
    output logic [1:0]        lut5_out,
    output logic              lut6_out
);

    logic [TBL_W-1:0]  tbl_q;
    logic [MODE_W-1:0] mode_q;
    logic [LUT_K-1:0]  eff_in;

    fraclut_cfg_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_load  (tbl_load),
        .cfg_table (cfg_table),
        .mode_load (mode_load),
        .cfg_mode  (cfg_mode),
        .tbl_q     (tbl_q),
        .mode_q    (mode_q)
    );

    fraclut_force #(.K(LUT_K), .MW(MODE_W)) u_force (
        .raw_in (lut_in),
        .mode   (mode_q),
        .eff_in (eff_in)
    );

    fraclut_mux_tree #(.K(LUT_K)) u_tree (
        .tbl      (tbl_q),
        .sel      (eff_in),
        .tap_lo   (lut4_out),
        .tap_mid  (lut5_out),
        .tap_root (lut6_out)
    );

    // R5
    root_from_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lut6_out == ((lut_in[5] | mode_q[1]) ? lut5_out[1] : lut5_out[0]));

    // R6
    mid_from_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lut_in[4] | mode_q[0]) |-> (lut5_out == lut4_out));

    // R8
    dual4_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b11) |-> (lut6_out == lut5_out[1]));

endmodule

// File: tb/tb_fraclut6.sv
`timescale 1ns/1ps
module tb_fraclut6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_load = 1'b0;
    logic [63:0] cfg_table = '0;
    logic        mode_load = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [5:0]  lut_in = '0;
    logic [1:0]  lut4_out, lut5_out;
    logic        lut6_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fraclut6 dut (
        .clk(clk), .rst_n(rst_n), .tbl_load(tbl_load), .cfg_table(cfg_table),
        .mode_load(mode_load), .cfg_mode(cfg_mode), .lut_in(lut_in),
        .lut4_out(lut4_out), .lut5_out(lut5_out), .lut6_out(lut6_out)
    );

    // Packed as {lut6, lut5[1], lut5[0], lut4[1], lut4[0]}
    typedef struct packed {
        logic [63:0] t;
        logic [1:0]  m;
        logic [5:0]  i;
        logic [4:0]  e;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{64'h8000_0000_0000_0001, 2'b00, 6'd0,  5'b10101},
        '{64'h8000_0000_0000_0001, 2'b00, 6'd63, 5'b11000},
        '{64'h8000_0000_0000_0001, 2'b11, 6'd0,  5'b00001},
        '{64'h8000_0000_0000_0001, 2'b11, 6'd15, 5'b11000},
        '{64'h8000_0000_0000_0001, 2'b01, 6'd47, 5'b11000},
        '{64'h0000_0001_0000_0000, 2'b10, 6'd0,  5'b11010}
    };

    function automatic logic [4:0] ref_out(input logic [63:0] t,
                                           input logic [1:0] m,
                                           input logic [5:0] i);
        logic f4, f5;
        logic [3:0] lo;
        f4 = i[4] | m[0];
        f5 = i[5] | m[1];
        lo = i[3:0];
        return {t[{f5, f4, lo}], t[{1'b1, f4, lo}], t[{1'b0, f4, lo}],
                t[{2'b10, lo}], t[{2'b00, lo}]};
    endfunction

    function automatic logic [4:0] outs();
        return {lut6_out, lut5_out[1], lut5_out[0], lut4_out[1], lut4_out[0]};
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: in=%0d got %b expected %b", req, lut_in, outs(), exp);
        end
    endtask

    task automatic load(input bit do_t, input logic [63:0] t,
                        input bit do_m, input logic [1:0] m);
        @(negedge clk);
        cfg_table = t;  cfg_mode = m;
        tbl_load = do_t; mode_load = do_m;
        @(negedge clk);
        tbl_load = 1'b0; mode_load = 1'b0;
    endtask

    task automatic apply(input logic [5:0] i);
        lut_in = i;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: cleared table gives zero on every output
        for (int i = 0; i < 64; i += 21) begin
            apply(6'(i));
            check("R1 cleared table", 5'b00000);
        end

        // R1 / R8: load table only, mode stays at its reset value 11
        load(1'b1, 64'h8000_0000_0000_0001, 1'b0, 2'b00);
        apply(6'd0);   check("R1 reset mode 11", 5'b00001);
        apply(6'd15);  check("R1 reset mode 11", 5'b11000);
        apply(6'd63);  check("R8 upper inputs ignored", 5'b11000);

        // R4 R5 R6 R7: vector table
        foreach (VECS[n]) begin
            load(1'b1, VECS[n].t, 1'b1, VECS[n].m);
            apply(VECS[n].i);
            check("R4/R5/R6/R7 vector", VECS[n].e);
        end

        // R3: config buses move with strobes low; outputs must not change
        load(1'b1, 64'hF0F0_0FF0_3C3C_A5A5, 1'b1, 2'b00);
        @(negedge clk);
        cfg_table = ~64'hF0F0_0FF0_3C3C_A5A5;
        cfg_mode  = 2'b11;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            apply(6'(i));
            check("R3 held config", ref_out(64'hF0F0_0FF0_3C3C_A5A5, 2'b00, 6'(i)));
        end

        // R2: mode written alone keeps the table
        load(1'b0, '0, 1'b1, 2'b10);
        apply(6'd5);
        check("R2 mode-only write", ref_out(64'hF0F0_0FF0_3C3C_A5A5, 2'b10, 6'd5));

        // R9 with R4-R8: sweep of random tables, all modes, all inputs
        for (int r = 0; r < 4; r++) begin
            logic [63:0] t;
            t = {$urandom(), $urandom()};
            for (int m = 0; m < 4; m++) begin
                load(1'b1, t, 1'b1, 2'(m));
                for (int i = 0; i < 64; i++) begin
                    apply(6'(i));
                    check("R9 combinational sweep", ref_out(t, 2'(m), 6'(i)));
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule